// File: doc/BRIEF.md
# VLIW Execute-Packet Dispatcher

This block sits between instruction fetch and the issue stage of an eight-lane VLIW core. Each fetch packet is a 256-bit word made of eight 32-bit instruction slots. Slot 0 occupies bits 31:0, and slot 7 occupies bits 255:224. Bit 0 of every instruction is a chaining flag. When the flag is set, the next slot joins the same issue cycle. When the flag is clear, the current execute packet ends at that slot. Because parallelism is encoded this way, the compiler never pads a packet with no-ops to fill unused lanes.

The dispatcher stores one fetch packet and issues one execute packet per accepted issue cycle. Each execute packet holds one to eight instructions. They are packed into the low issue lanes, starting at lane 0, and come with a lane mask and an instruction count. A fetch packet may need several issue cycles. While it is being worked through, the dispatcher holds off the fetch side. It accepts the next packet in the same cycle that the final execute packet of the current one is taken, so issue continues without a gap.

Top module: `vliw_dispatch`

## Requirements
- R1: During and right after reset, `issValid` is 0, `issMask` is 0 and `fpReady` is 1.
- R2: `fpReady` is 1 exactly when no fetch packet is held, or when the final execute packet of the held packet is being accepted in this cycle (`issValid` and `issReady` both 1). A packet is taken only on a cycle with `fpValid` and `fpReady` both 1.
- R3: An execute packet that starts at slot s runs through every following slot while the previous slot's bit 0 is 1. It ends at the first slot whose bit 0 is 0.
- R4: The dispatcher ignores bit 0 of slot 7 and treats it as 0, so an execute packet never continues into the next fetch packet.
- R5: Issue lane j carries slot s+j of the current execute packet. Unused lanes carry zero. `issMask` has its low `issCount` bits set and all other bits clear.
- R6: `issCount` equals the number of instructions in the execute packet, from 1 to 8.
- R7: While `issValid` is 1 and `issReady` is 0, `issValid`, `issInsn`, `issMask` and `issCount` hold their values into the next cycle.
- R8: When each cycle has `issReady` at 1 and the next packet is offered in time, consecutive fetch packets issue with no idle cycle between them.
- R9: A fetch packet accepted at a clock edge presents its first execute packet right after that edge.
- R10: A packet with every flag at 0 issues as eight single-instruction packets. A packet with every flag at 1 issues as one eight-wide packet.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| fpValid | input | 1 | Fetch packet offered |
| fpReady | output | 1 | Dispatcher takes the offered packet this cycle |
| fpData | input | 256 | Fetch packet, slot k at bits 32k+31:32k |
| issValid | output | 1 | An execute packet is presented |
| issReady | input | 1 | Issue stage accepts the presented packet |
| issInsn | output | 256 | Left-justified instructions, lane j at bits 32j+31:32j |
| issMask | output | 8 | Lane valid mask |
| issCount | output | 4 | Number of instructions in the execute packet |

## Verification
The embedded assertions check the handshake rules on every cycle. They cover output hold during a stall, acceptance of a new packet only when the issue side is also taking its last group, presentation in the cycle after a load, and agreement between the mask and the count. The bench's scenarios are the only place where the actual grouping is shown to be correct. They exercise chains starting at every slot, the ignored flag on slot 7, all-serial and all-parallel packets, and gap-free issue across packet boundaries. A behavioural reference model checks these against the outputs on every clock.

// File: rtl/dispatch_pkg.sv
package dispatch_pkg;

  // Strobes from the sequencing control to the packet datapath.
  typedef struct packed {
    logic loadPkt;  // capture the offered fetch packet
    logic live;     // a fetch packet is held and being issued
  } dispCtrlT;

  typedef enum logic {
    ST_EMPTY = 1'b0,
    ST_HOLD  = 1'b1
  } dispStateT;

endpackage

// File: rtl/dispatch_datapath.sv
module dispatch_datapath
  import dispatch_pkg::*;
#(
  parameter int SLOTS  = 8,
  parameter int INSN_W = 32,
  parameter int IDX_W  = $clog2(SLOTS),
  parameter int CNT_W  = $clog2(SLOTS + 1)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  dispCtrlT                ctrl,
  input  logic [SLOTS*INSN_W-1:0] fpData,
  input  logic [IDX_W-1:0]        cursor,
  output logic [IDX_W-1:0]        grpEnd,
  output logic [SLOTS*INSN_W-1:0] issInsn,
  output logic [SLOTS-1:0]        issMask,
  output logic [CNT_W-1:0]        issCount
);

  localparam int LAST = SLOTS - 1;

  logic [SLOTS*INSN_W-1:0] pktReg;
  logic [INSN_W-1:0]       slotArr [SLOTS];
  logic [SLOTS-1:0]        chainBit;
  logic                    endFound;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pktReg <= '0;
    end else if (ctrl.loadPkt) begin
      pktReg <= fpData;
    end
  end

  for (genvar k = 0; k < SLOTS; k++) begin : g_slot
    assign slotArr[k]  = pktReg[k*INSN_W +: INSN_W];
    // The last slot never chains into the next fetch packet.
    if (k == LAST) begin : g_tail
      assign chainBit[k] = 1'b0;
    end else begin : g_body
      assign chainBit[k] = pktReg[k*INSN_W];
    end
  end

  // Scan forward from the cursor to the first slot that does not chain.
  always_comb begin
    grpEnd   = IDX_W'(LAST);
    endFound = 1'b0;
    for (int k = 0; k < SLOTS; k++) begin
      if (!endFound && k >= int'(cursor) && !chainBit[k]) begin
        grpEnd   = IDX_W'(k);
        endFound = 1'b1;
      end
    end
  end

  // Left-justify the group into the issue lanes.
  for (genvar j = 0; j < SLOTS; j++) begin : g_lane
    int   srcIdx;
    logic laneOn;
    always_comb begin
      srcIdx = int'(cursor) + j;
      laneOn = ctrl.live && (srcIdx <= int'(grpEnd));
      issMask[j] = laneOn;
      issInsn[j*INSN_W +: INSN_W] =
        laneOn ? slotArr[IDX_W'(srcIdx)] : '0;
    end
  end

  assign issCount = ctrl.live ? CNT_W'(int'(grpEnd) - int'(cursor) + 1) : '0;

  // R5
  mask_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.live |-> (issMask[0] && ($countones(issMask) == int'(issCount))));

  // R5
  idle_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.live |-> (issMask == '0));

  // R3
  end_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.live |-> (grpEnd >= cursor));

  // R7
  pkt_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.loadPkt |=> $stable(pktReg));

endmodule

// File: rtl/dispatch_ctrl.sv
module dispatch_ctrl
  import dispatch_pkg::*;
#(
  parameter int SLOTS = 8,
  parameter int IDX_W = $clog2(SLOTS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             fpValid,
  input  logic             issReady,
  input  logic [IDX_W-1:0] grpEnd,
  output logic             fpReady,
  output logic             issValid,
  output logic [IDX_W-1:0] cursor,
  output dispCtrlT         ctrl
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SLOTS - 1);

  dispStateT state;
  logic      lastGrp;
  logic      issFire;

  assign issValid = (state == ST_HOLD);
  assign lastGrp  = (grpEnd == LAST_IDX);
  assign issFire  = issValid && issReady;
  assign fpReady  = (state == ST_EMPTY) || (issFire && lastGrp);

  assign ctrl.loadPkt = fpValid && fpReady;
  assign ctrl.live    = issValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_EMPTY;
      cursor <= '0;
    end else if (ctrl.loadPkt) begin
      state  <= ST_HOLD;
      cursor <= '0;
    end else if (issFire && lastGrp) begin
      state  <= ST_EMPTY;
      cursor <= '0;
    end else if (issFire) begin
      cursor <= grpEnd + 1'b1;
    end
  end

  // R2
  fetch_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fpReady && issValid) |-> issReady);

  // R7
  stall_cursor_chk: assert property (@(posedge clk) disable iff (!rstN)
    (issValid && !issReady) |=> (issValid && $stable(cursor)));

  // R4
  advance_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    (issFire && !fpReady) |=> (issValid && cursor > $past(cursor)));

endmodule

// File: rtl/vliw_dispatch.sv
module vliw_dispatch
  import dispatch_pkg::*;
#(
  parameter int SLOTS  = 8,
  parameter int INSN_W = 32,
  localparam int IDX_W = $clog2(SLOTS),
  localparam int CNT_W = $clog2(SLOTS + 1)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    fpValid,
  output logic                    fpReady,
  input  logic [SLOTS*INSN_W-1:0] fpData,
  output logic                    issValid,
  input  logic                    issReady,
  output logic [SLOTS*INSN_W-1:0] issInsn,
  output logic [SLOTS-1:0]        issMask,
  output logic [CNT_W-1:0]        issCount
);

  dispCtrlT         ctrl;
  logic [IDX_W-1:0] cursor;
  logic [IDX_W-1:0] grpEnd;

  dispatch_ctrl #(
    .SLOTS(SLOTS),
    .IDX_W(IDX_W)
  ) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .fpValid (fpValid),
    .issReady(issReady),
    .grpEnd  (grpEnd),
    .fpReady (fpReady),
    .issValid(issValid),
    .cursor  (cursor),
    .ctrl    (ctrl)
  );

  dispatch_datapath #(
    .SLOTS (SLOTS),
    .INSN_W(INSN_W),
    .IDX_W (IDX_W),
    .CNT_W (CNT_W)
  ) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .ctrl    (ctrl),
    .fpData  (fpData),
    .cursor  (cursor),
    .grpEnd  (grpEnd),
    .issInsn (issInsn),
    .issMask (issMask),
    .issCount(issCount)
  );

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (issValid && !issReady) |=>
      (issValid && $stable(issInsn) && $stable(issMask) && $stable(issCount)));

  // R9
  load_present_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fpValid && fpReady) |=> (issValid && issMask[0]));

  // R6
  count_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    issValid |-> (issCount >= CNT_W'(1) && issCount <= CNT_W'(SLOTS)));

endmodule

// File: tb/vliw_dispatch_tb_top.sv
module vliw_dispatch_tb_top;

  localparam int PERIOD = 10;
  localparam int NS = 8;
  localparam int W  = 32;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            fpValid = 1'b0;
  logic            fpReady;
  logic [NS*W-1:0] fpData = '0;
  logic            issValid;
  logic            issReady = 1'b1;
  logic [NS*W-1:0] issInsn;
  logic [NS-1:0]   issMask;
  logic [3:0]      issCount;

  int checks = 0;
  int failures = 0;
  string curReq = "R3";

  logic [NS*W-1:0] qInsn [$];
  logic [NS-1:0]   qMask [$];
  int              qCnt  [$];

  logic            prevStall = 1'b0;
  logic [NS*W-1:0] prevInsn = '0;

  always #(PERIOD/2) clk = ~clk;

  vliw_dispatch dut_i (
    .clk     (clk),
    .rstN    (rstN),
    .fpValid (fpValid),
    .fpReady (fpReady),
    .fpData  (fpData),
    .issValid(issValid),
    .issReady(issReady),
    .issInsn (issInsn),
    .issMask (issMask),
    .issCount(issCount)
  );

  task automatic chk(input bit ok, input string req,
                     input logic [NS*W-1:0] act, input logic [NS*W-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [W-1:0] insnOf(input logic [15:0] tag, input int k, input bit p);
    return {tag, 8'(k), 7'h2a, p};
  endfunction

  function automatic logic [NS*W-1:0] mkPkt(input logic [NS-1:0] pm, input logic [15:0] tag);
    logic [NS*W-1:0] d = '0;
    for (int k = 0; k < NS; k++) d[k*W +: W] = insnOf(tag, k, pm[k]);
    return d;
  endfunction

  // Reference grouping: chain while the flag is set, never past slot 7.
  task automatic pushGroups(input logic [NS*W-1:0] d);
    int s = 0;
    while (s < NS) begin
      int e = s;
      logic [NS*W-1:0] v = '0;
      logic [NS-1:0] m = '0;
      while (e < NS - 1 && d[e*W] == 1'b1) e++;
      for (int j = 0; j <= e - s; j++) begin
        v[j*W +: W] = d[(s+j)*W +: W];
        m[j] = 1'b1;
      end
      qInsn.push_back(v);
      qMask.push_back(m);
      qCnt.push_back(e - s + 1);
      s = e + 1;
    end
  endtask

  task automatic compareNow();
    bit expValid = (qInsn.size() > 0);
    bit expFpR = (qInsn.size() == 0) || (issReady && qInsn.size() == 1);
    chk(issValid == expValid, "R9", NS*W'(issValid), NS*W'(expValid));
    chk(fpReady == expFpR, "R2", NS*W'(fpReady), NS*W'(expFpR));
    if (expValid && issValid) begin
      chk(issInsn == qInsn[0], curReq, issInsn, qInsn[0]);
      chk(issMask == qMask[0], "R5", NS*W'(issMask), NS*W'(qMask[0]));
      chk(int'(issCount) == qCnt[0], "R6", NS*W'(issCount), NS*W'(qCnt[0]));
    end
    if (prevStall) chk(issValid && issInsn == prevInsn, "R7", issInsn, prevInsn);
  endtask

  task automatic oneCycle(input bit fv, input logic [NS*W-1:0] fd, input bit ir,
                          output bit accepted);
    @(negedge clk);
    fpValid = fv;
    fpData = fd;
    issReady = ir;
    #1;
    compareNow();
    accepted = fv && fpReady;
    prevStall = issValid && !ir;
    prevInsn = issInsn;
    if (qInsn.size() > 0 && ir) begin
      void'(qInsn.pop_front());
      void'(qMask.pop_front());
      void'(qCnt.pop_front());
    end
    if (accepted) pushGroups(fd);
  endtask

  function automatic bit pickReady(input int stallPct);
    if (stallPct == 0) return 1'b1;
    return ($urandom_range(99) >= stallPct);
  endfunction

  task automatic sendPkt(input logic [NS-1:0] pm, input logic [15:0] tag, input int stallPct);
    logic [NS*W-1:0] d = mkPkt(pm, tag);
    bit done = 1'b0;
    int guard = 0;
    while (!done && guard < 2000) begin
      oneCycle(1'b1, d, pickReady(stallPct), done);
      guard++;
    end
  endtask

  task automatic drain(input int stallPct);
    bit acc;
    int guard = 0;
    while (qInsn.size() > 0 && guard < 2000) begin
      oneCycle(1'b0, '0, pickReady(stallPct), acc);
      guard++;
    end
    oneCycle(1'b0, '0, 1'b1, acc);
  endtask

  initial begin
    #(PERIOD*150000);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    bit acc;
    // R1: reset state
    #(PERIOD*2 + 1);
    chk(issValid == 1'b0, "R1", NS*W'(issValid), '0);
    chk(issMask == '0, "R1", NS*W'(issMask), '0);
    chk(fpReady == 1'b1, "R1", NS*W'(fpReady), 1);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    chk(issValid == 1'b0 && fpReady == 1'b1, "R1", NS*W'({issValid, fpReady}), 1);

    // R9: first group appears the cycle after acceptance
    curReq = "R9";
    oneCycle(1'b1, mkPkt(8'h00, 16'h1000), 1'b1, acc);
    oneCycle(1'b0, '0, 1'b0, acc);
    chk(issValid == 1'b1 && issCount == 4'd1, "R9", NS*W'(issValid), 1);
    drain(0);

    // R10: all serial, all parallel
    curReq = "R10";
    sendPkt(8'h00, 16'h2000, 0);
    drain(0);
    sendPkt(8'hFF, 16'h2100, 0);
    drain(0);

    // R4: flag on slot 7 alone is ignored; chain reaching slot 7 stops there
    curReq = "R4";
    sendPkt(8'h80, 16'h3000, 0);
    drain(0);
    sendPkt(8'hF0, 16'h3100, 0);
    drain(0);

    // R3: mixed chains at various starting slots
    curReq = "R3";
    sendPkt(8'b0011_0101, 16'h4000, 0);
    drain(0);
    sendPkt(8'b0100_1110, 16'h4100, 0);
    drain(0);
    sendPkt(8'b0111_1011, 16'h4200, 0);
    drain(0);

    // R7: random downstream stalls
    curReq = "R7";
    for (int i = 0; i < 40; i++) sendPkt(8'($urandom), 16'(16'h5000 + i), 40);
    drain(40);

    // R8: back-to-back packets with ready always high
    curReq = "R8";
    for (int i = 0; i < 30; i++) sendPkt(8'($urandom), 16'(16'h6000 + i), 0);
    drain(0);

    // R5: left justification across every single-slot start
    curReq = "R5";
    sendPkt(8'b0000_0001, 16'h7000, 0);
    sendPkt(8'b0110_0000, 16'h7100, 20);
    drain(0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule